// File: doc/BRIEF.md
# Synchronized Clock Stop Gate

This block turns a free-running clock into a gated true/complement clock pair that can be stopped on request. Two asynchronous, active-low requests steer it. A stop request halts only the gated pair. A power-down request halts the pair, overrides the stop request and raises an acknowledge flag. The flag stands in for the point where the oscillator and PLL may be shut off. Both requests pass through a two-flop synchronizer in the clock domain before the block uses them.

The enable that gates the clock is retimed on the falling edge and then ANDed with the clock. Each high phase on the true output is therefore either passed whole or not at all. When stopped, the true output rests low and the complement output rests high. After every restart the pair runs for at least `MIN_RUN` full pulses before a stop can take effect. A stop request seen inside that window is remembered and applied when the window closes.

Top module: `clk_stop_gate`

## Requirements
- R1: While `rst_n` is low, `clk_t_o` is low, `clk_c_o` is high and `pd_ack_o` is low. With both requests inactive, the first high pulse after reset release appears on the third rising edge after the release (edges counted from 0).
- R2: When `stop_n` goes low before rising edge S on a pair that has finished its minimum run window, `clk_t_o` still pulses high at edges S, S+1 and S+2 and stays low from edge S+3 on.
- R3: When `stop_n` returns high before rising edge E on a stopped pair, `clk_t_o` is still low at edge E+2 and gives its first high pulse at edge E+3.
- R4: After each restart, `clk_t_o` gives at least `MIN_RUN` (default 100) high pulses before a stop takes effect. A stop held from a gap of 1 to `MIN_RUN` cycles after release yields exactly `MIN_RUN` pulses. A gap of g cycles above that yields exactly g pulses.
- R5: A stop request that covers a single rising edge inside the window is remembered. The pair stops once the window has closed (after exactly `MIN_RUN` pulses), stays low for one cycle and then restarts with a new window.
- R6: Every high pulse on `clk_t_o` lasts exactly one half period of `clk`. No shortened pulse occurs.
- R7: `clk_c_o` is always the inverse of `clk_t_o`, so a stopped pair rests with the true output low and the complement output high.
- R8: When `pd_n` goes low before rising edge P, `clk_t_o` pulses at P, P+1 and P+2 and is held low from the falling edge after P+2. This holds even inside a minimum run window.
- R9: `pd_ack_o` rises at edge P+3, the first rising edge after the outputs are held low. It is low again by the third edge after `pd_n` returns high, and it never rises while only a stop is requested.
- R10: While power-down is active, toggling `stop_n` produces no pulse and does not drop `pd_ack_o`.
- R11: After power-down is released, the pair stays stopped if a stop is requested. Otherwise it restarts on its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stop_n | input | 1 | Asynchronous active-low request to stop the gated pair |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| clk_t_o | output | 1 | Gated true clock, rests low |
| clk_c_o | output | 1 | Gated complement clock, rests high |
| pd_ack_o | output | 1 | Set once power-down has taken hold of the outputs |

## Verification
Each result is due a fixed number of rising edges after the stimulus. Inputs change on a falling edge ahead of a named edge, and the two synchronizer flops plus the controller flop set the counts: a stop or power-down silences the output from edge +3, a release gives its first pulse at edge +3, and the acknowledge rises at edge +3. The bench samples 2 ns after the named rising edge, in the high phase, where a passed pulse is visible. It also counts every rising edge of the true output and measures the width of every high phase. This lets the minimum run window and the absence of runt pulses be checked as totals over each scenario.

// File: rtl/csg_pkg.sv
`timescale 1ns/1ps
package csg_pkg;
  // Controller states; power-down wins over every other state.
  typedef enum logic [1:0] {
    CS_HALT = 2'd0,
    CS_RUN  = 2'd1,
    CS_PDN  = 2'd2
  } csg_state_e;

  // Synchronizer lane positions
  localparam int unsigned LANE_STOP = 0;
  localparam int unsigned LANE_PD   = 1;
  localparam int unsigned LANES     = 2;
endpackage

// File: rtl/csg_sync.sv
`timescale 1ns/1ps
module csg_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  generate
    if (STAGES == 1) begin : g_single
      assign stg_d = d_i;
    end else begin : g_chain
      assign stg_d = {stg_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/csg_ctrl.sv
`timescale 1ns/1ps
module csg_ctrl
  import csg_pkg::*;
#(
  parameter int unsigned MIN_RUN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,   // synchronized, active high
  input  logic pd_req,     // synchronized, active high
  input  logic gate_en_i,  // falling-edge retimed enable, fed back
  output logic run_en_o,
  output logic pd_ack_o
);
  localparam int unsigned CNT_W = $clog2(MIN_RUN + 1);
  localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(MIN_RUN - 1);

  csg_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             pend_q, pend_d;
  logic             ack_q, ack_d;
  logic             win_done;
  logic             cnt_en;

  assign win_done = (cnt_q == WIN_LAST);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    pend_d  = pend_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    unique case (state_q)
      CS_RUN: begin
        if (!win_done) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q + 1'b1;
          if (stop_req) pend_d = 1'b1;
        end else if (stop_req || pend_q) begin
          state_d = CS_HALT;
          run_d   = 1'b0;
          pend_d  = 1'b0;
        end
      end
      CS_HALT: begin
        if (!stop_req) begin
          state_d = CS_RUN;
          run_d   = 1'b1;
          cnt_en  = 1'b1;
          cnt_d   = '0;
        end
      end
      CS_PDN: begin
        if (!pd_req) state_d = CS_HALT;
      end
      default: begin
        state_d = CS_HALT;
        run_d   = 1'b0;
      end
    endcase
    if (pd_req) begin
      state_d = CS_PDN;
      run_d   = 1'b0;
      pend_d  = 1'b0;
    end
    ack_d = (state_q == CS_PDN) && !gate_en_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CS_HALT;
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      ack_q   <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      pend_q  <= pend_d;
      ack_q   <= ack_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign run_en_o = run_q;
  assign pd_ack_o = ack_q;
endmodule

// File: rtl/csg_gate.sv
`timescale 1ns/1ps
module csg_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en_i,
  output logic gate_en_o,
  output logic clk_t_o,
  output logic clk_c_o
);
  logic gate_q;

  // Retimed while clk is low, so the AND below never cuts a high phase.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= run_en_i;
  end

  assign gate_en_o = gate_q;
  assign clk_t_o   = clk & gate_q;
  assign clk_c_o   = ~clk_t_o;
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate
  import csg_pkg::*;
#(
  parameter int unsigned MIN_RUN     = 100,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stop_n,
  input  logic pd_n,
  output logic clk_t_o,
  output logic clk_c_o,
  output logic pd_ack_o
);
  // Stop lane resets asserted, power-down lane resets idle.
  localparam logic [LANES-1:0] SYNC_RST = LANES'(1) << LANE_STOP;

  logic [LANES-1:0] req_raw;
  logic [LANES-1:0] req_s;
  logic             stop_req_s;
  logic             pd_req_s;
  logic             run_en;
  logic             gate_en;

  always_comb begin
    req_raw            = '0;
    req_raw[LANE_STOP] = ~stop_n;
    req_raw[LANE_PD]   = ~pd_n;
  end

  csg_sync #(
    .WIDTH  (LANES),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) i_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (req_raw),
    .q_o  (req_s)
  );

  assign stop_req_s = req_s[LANE_STOP];
  assign pd_req_s   = req_s[LANE_PD];

  csg_ctrl #(
    .MIN_RUN(MIN_RUN)
  ) i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req_s),
    .pd_req   (pd_req_s),
    .gate_en_i(gate_en),
    .run_en_o (run_en),
    .pd_ack_o (pd_ack_o)
  );

  csg_gate i_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en_i (run_en),
    .gate_en_o(gate_en),
    .clk_t_o  (clk_t_o),
    .clk_c_o  (clk_c_o)
  );
endmodule

// File: rtl/clk_stop_gate_chk.sv
`timescale 1ns/1ps
module clk_stop_gate_chk #(
  parameter int unsigned MIN_RUN = 100
) (
  input logic clk,
  input logic rst_n,
  input logic stop_req,
  input logic pd_req,
  input logic run_en,
  input logic gate_en,
  input logic pd_ack
);
  localparam int unsigned CW = $clog2(MIN_RUN + 2);
  localparam logic [CW-1:0] CSAT = CW'(MIN_RUN);

  // Rising edges seen with the gate open since it last opened (saturating).
  logic [CW-1:0] on_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            on_cnt <= '0;
    else if (!gate_en)     on_cnt <= '0;
    else if (on_cnt != CSAT) on_cnt <= on_cnt + 1'b1;
  end

  // R4: a stop that is not caused by power-down comes after the full window.
  assert_min_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gate_en) && !$past(pd_req)) |-> (on_cnt >= CSAT));

  // R3: the gate only opens after a cycle with neither request present.
  assert_restart_on_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> (!$past(stop_req) && !$past(pd_req)));

  // R8: a synchronized power-down request closes the run enable next cycle.
  assert_pd_forces_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pd_req) |-> !run_en);

  // R9: acknowledge only follows power-down and only with the gate closed.
  assert_ack_after_pd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pd_ack) |-> $past(pd_req));

  assert_ack_gate_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pd_ack |-> !gate_en);
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.MIN_RUN(MIN_RUN)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .stop_req(stop_req_s),
  .pd_req  (pd_req_s),
  .run_en  (run_en),
  .gate_en (gate_en),
  .pd_ack  (pd_ack_o)
);

// File: tb/test_clk_stop_gate.sv
`timescale 1ns/1ps
module test_clk_stop_gate;
  localparam int unsigned MIN_RUN = 100;
  localparam int unsigned VEC_N   = 8;
  // gap between stop release and re-request, and expected pulse total (R4, R2)
  localparam int unsigned GAP [VEC_N] = '{1, 5, 50, 99, 100, 101, 130, 200};
  localparam int unsigned EXPP[VEC_N] = '{100, 100, 100, 100, 100, 101, 130, 200};

  logic clk;
  logic rst_n;
  logic stop_n;
  logic pd_n;
  logic clk_t_o;
  logic clk_c_o;
  logic pd_ack_o;

  int n_chk;
  int n_bad;
  int pulses;
  int runts;
  int widths;
  int base;
  time t_rise;
  bit  rise_seen;

  clk_stop_gate #(.MIN_RUN(MIN_RUN)) i_clk_stop_gate (
    .clk     (clk),
    .rst_n   (rst_n),
    .stop_n  (stop_n),
    .pd_n    (pd_n),
    .clk_t_o (clk_t_o),
    .clk_c_o (clk_c_o),
    .pd_ack_o(pd_ack_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Pulse monitor: counts and measures every high phase of the true output.
  initial begin
    pulses    = 0;
    runts     = 0;
    widths    = 0;
    rise_seen = 1'b0;
    t_rise    = 0;
  end
  always @(posedge clk_t_o) begin
    pulses    = pulses + 1;
    t_rise    = $time;
    rise_seen = 1'b1;
  end
  always @(negedge clk_t_o) begin
    if (rise_seen) begin
      widths = widths + 1;
      if (($time - t_rise) != 5) runts = runts + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic at_high(input int k);
    repeat (k) @(posedge clk);
    #2;
  endtask

  initial begin
    #1_000_000;
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    n_chk  = 0;
    n_bad  = 0;
    rst_n  = 1'b0;
    stop_n = 1'b1;
    pd_n   = 1'b1;

    // R1: reset state
    at_high(2);
    chk(clk_t_o == 1'b0, "R1 true low in reset", int'(clk_t_o), 0);
    chk(clk_c_o == 1'b1, "R1 complement high in reset", int'(clk_c_o), 1);
    chk(pd_ack_o == 1'b0, "R1 ack low in reset", int'(pd_ack_o), 0);
    @(negedge clk);
    rst_n = 1'b1;             // before edge R0
    at_high(3);               // edge R2
    chk(clk_t_o == 1'b0, "R1 still low at edge 2", int'(clk_t_o), 0);
    at_high(1);               // edge R3
    chk(clk_t_o == 1'b1, "R1 first pulse at edge 3", int'(clk_t_o), 1);

    // R7: complement in both phases while running
    chk(clk_c_o == ~clk_t_o, "R7 pair inverse high phase", int'(clk_c_o), int'(~clk_t_o));
    @(negedge clk); #2;
    chk(clk_c_o == ~clk_t_o, "R7 pair inverse low phase", int'(clk_c_o), int'(~clk_t_o));

    // R2: stop after the window has closed
    repeat (120) @(negedge clk);
    stop_n = 1'b0;            // before edge S
    at_high(3);               // S+2
    chk(clk_t_o == 1'b1, "R2 pulse at S+2", int'(clk_t_o), 1);
    at_high(1);               // S+3
    chk(clk_t_o == 1'b0, "R2 low at S+3", int'(clk_t_o), 0);
    chk(clk_c_o == 1'b1, "R7 complement rests high", int'(clk_c_o), 1);
    repeat (10) @(negedge clk);

    // R4 / R2: table of release-to-request gaps
    for (int v = 0; v < VEC_N; v++) begin
      @(negedge clk);
      base   = pulses;
      stop_n = 1'b1;          // before edge E
      repeat (GAP[v]) @(negedge clk);
      stop_n = 1'b0;          // before edge E+gap
      repeat (MIN_RUN + 20) @(negedge clk);
      chk((pulses - base) == int'(EXPP[v]), "R4 pulses per restart",
          pulses - base, int'(EXPP[v]));
    end

    // R5: one-edge stop pulse inside the window
    @(negedge clk);
    base   = pulses;
    stop_n = 1'b1;            // before edge E
    repeat (20) @(negedge clk);
    stop_n = 1'b0;            // covers edge E+20 only
    @(negedge clk);
    stop_n = 1'b1;
    at_high(83);              // E+103
    chk(clk_t_o == 1'b0, "R5 one low cycle after window", int'(clk_t_o), 0);
    chk((pulses - base) == int'(MIN_RUN), "R5 pulses before held stop",
        pulses - base, int'(MIN_RUN));
    at_high(1);               // E+104
    chk(clk_t_o == 1'b1, "R5 restart after held stop", int'(clk_t_o), 1);

    // R8 / R9: power-down from a running pair
    repeat (150) @(negedge clk);
    chk(pd_ack_o == 1'b0, "R9 ack low while running", int'(pd_ack_o), 0);
    base = pulses;
    pd_n = 1'b0;              // before edge P
    at_high(3);               // P+2
    chk(clk_t_o == 1'b1, "R8 pulse at P+2", int'(clk_t_o), 1);
    chk(pd_ack_o == 1'b0, "R9 ack not yet at P+2", int'(pd_ack_o), 0);
    at_high(1);               // P+3
    chk(clk_t_o == 1'b0, "R8 low at P+3", int'(clk_t_o), 0);
    chk(pd_ack_o == 1'b1, "R9 ack at P+3", int'(pd_ack_o), 1);
    repeat (5) @(negedge clk);
    chk((pulses - base) == 3, "R8 pulses after power-down", pulses - base, 3);

    // R10: stop toggles are ignored under power-down
    base = pulses;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      stop_n = ~stop_n;
      repeat (4) @(negedge clk);
      chk(pd_ack_o == 1'b1, "R10 ack held during stop toggles", int'(pd_ack_o), 1);
    end
    chk((pulses - base) == 0, "R10 no pulse under power-down", pulses - base, 0);
    chk(stop_n == 1'b0, "R10 stop left asserted", int'(stop_n), 0);

    // R11 / R9: release power-down while stop is held
    @(negedge clk);
    base = pulses;
    pd_n = 1'b1;              // before edge Q
    repeat (6) @(negedge clk);
    chk(pd_ack_o == 1'b0, "R9 ack cleared after release", int'(pd_ack_o), 0);
    chk((pulses - base) == 0, "R11 stays stopped with stop held", pulses - base, 0);
    chk(clk_c_o == 1'b1, "R7 complement high while stopped", int'(clk_c_o), 1);

    // R3: release latency
    @(negedge clk);
    base   = pulses;
    stop_n = 1'b1;            // before edge E
    at_high(3);               // E+2
    chk(clk_t_o == 1'b0, "R3 still low at E+2", int'(clk_t_o), 0);
    at_high(1);               // E+3
    chk(clk_t_o == 1'b1, "R3 first pulse at E+3", int'(clk_t_o), 1);

    // R8: power-down inside the window overrides it
    repeat (7) @(negedge clk);
    pd_n = 1'b0;              // before edge E+10
    repeat (10) @(negedge clk);
    chk((pulses - base) == 10, "R8 power-down cuts the window", pulses - base, 10);
    chk(pd_ack_o == 1'b1, "R9 ack after early power-down", int'(pd_ack_o), 1);

    // R11: release power-down with no stop pending
    @(negedge clk);
    pd_n = 1'b1;
    at_high(10);
    chk(clk_t_o == 1'b1, "R11 restarts after power-down", int'(clk_t_o), 1);
    chk(pd_ack_o == 1'b0, "R9 ack low after restart", int'(pd_ack_o), 0);

    // R9: a plain stop never raises the acknowledge
    @(negedge clk);
    stop_n = 1'b0;
    repeat (130) @(negedge clk);
    at_high(1);
    chk(clk_t_o == 1'b0, "R2 stopped after window", int'(clk_t_o), 0);
    chk(pd_ack_o == 1'b0, "R9 no ack for stop only", int'(pd_ack_o), 0);

    // R6: every high phase measured full width
    chk(runts == 0, "R6 no shortened pulse", runts, 0);
    chk(widths > 1000, "R6 pulses were measured", widths, 1001);

    finish_run();
  end
endmodule